// File: doc/BRIEF.md
# Serial Two's Complement Converter

This block negates an unsigned binary word of any length as the bits stream past, one bit per clock. The word enters least significant bit first on `bit_in`, and the matching result bit leaves on `bit_out` in that same cycle, through combinational logic only. No word length is configured anywhere. The source raises `last_in` for exactly one cycle, together with the final bit of each word, and the converter is then ready for the next word on the following clock.

Internally the block holds a single state bit that selects one of two named states. In state `PASS_ST`, input bits are copied unchanged to the output. This continues through the first 1 of the word, which is also copied. The transition `FIRST_ONE` (a 1 arrives while `last_in` is 0) moves the machine to `FLIP_ST`. In `FLIP_ST`, every later bit is inverted on its way out. The transition `END_OF_WORD` (`last_in` is 1) returns the machine to `PASS_ST` from either state. The transition `HOLD` keeps the present state in every other case. A synchronous, active-high reset puts the machine in `PASS_ST`.

Top module: `twos_serial_conv`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes `PASS_ST`. The first bit after reset is copied unchanged to `bit_out`.
- R2: In `PASS_ST`, `bit_out` equals `bit_in`.
- R3: In `PASS_ST`, `bit_in`=1 with `last_in`=0 takes transition `FIRST_ONE`. The next bit is therefore inverted on `bit_out`.
- R4: In `PASS_ST`, `bit_in`=0 with `last_in`=0 keeps the machine in `PASS_ST` (`HOLD`).
- R5: In `FLIP_ST`, `bit_out` is the inverse of `bit_in`. The machine stays in `FLIP_ST` while `last_in` is 0.
- R6: `last_in`=1 at a clock edge takes transition `END_OF_WORD` to `PASS_ST` from either state. This holds even when the final bit is a 1 received in `PASS_ST`.
- R7: `bit_out` follows a change of `bit_in` within the same cycle, with no clock edge in between.
- R8: For a word of n bits with value v, the n output bits form (2^n - v) mod 2^n. Examples, written most significant bit first: 0011 gives 1101, 000 gives 000, 10 gives 10, and 10110100 gives 01001100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to `PASS_ST` |
| bit_in | input | 1 | Serial operand bit, least significant first |
| last_in | input | 1 | High for one cycle with the final bit of a word |
| bit_out | output | 1 | Serial result bit for the current `bit_in` |

## Verification
The word-end strobe and the first 1 of a word can arrive in the same cycle. This happens, for example, with a one-bit word of value 1, or with a word whose only 1 is its top bit. In that cycle the 1 must still be copied, and `END_OF_WORD` must win over `FIRST_ONE`. The bench provokes this with such words, sent back to back with random words that include single-bit and all-zero words. It judges the result by the first bit of the following word, which must be copied and not inverted.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic {
        PASS_ST = 1'b0,
        FLIP_ST = 1'b1
    } conv_state_e;
endpackage

// File: rtl/conv_next_state.sv
module conv_next_state
    import conv_pkg::*;
(
    input  conv_state_e state_q,
    input  logic        bit_in,
    input  logic        last_in,
    output conv_state_e state_d
);
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PASS_ST: begin
                if (last_in)      state_d = PASS_ST;   // END_OF_WORD
                else if (bit_in)  state_d = FLIP_ST;   // FIRST_ONE
                else              state_d = PASS_ST;   // HOLD
            end
            FLIP_ST: begin
                if (last_in)      state_d = PASS_ST;   // END_OF_WORD
                else              state_d = FLIP_ST;   // HOLD
            end
            default:              state_d = PASS_ST;
        endcase
    end
endmodule

// File: rtl/conv_out_logic.sv
module conv_out_logic
    import conv_pkg::*;
(
    input  conv_state_e state_q,
    input  logic        bit_in,
    output logic        bit_out
);
    always_comb begin
        bit_out = bit_in;
        unique case (state_q)
            PASS_ST: bit_out = bit_in;
            FLIP_ST: bit_out = ~bit_in;
            default: bit_out = bit_in;
        endcase
    end
endmodule

// File: rtl/twos_serial_conv.sv
module twos_serial_conv
    import conv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic last_in,
    output logic bit_out
);
    conv_state_e state_q;
    conv_state_e state_d;

    conv_next_state u_next (
        .state_q (state_q),
        .bit_in  (bit_in),
        .last_in (last_in),
        .state_d (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= PASS_ST;
        else     state_q <= state_d;
    end

    conv_out_logic u_out (
        .state_q (state_q),
        .bit_in  (bit_in),
        .bit_out (bit_out)
    );

    // R1: first cycle out of reset copies the input
    p_reset_copies_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bit_out == bit_in));

    // R3: a 1 without the word-end strobe in copy mode makes the next bit inverted
    p_first_one_flips_r3: assert property (@(posedge clk) disable iff (rst)
        (bit_out == bit_in && bit_in && !last_in) |=> (bit_out != bit_in));

    // R4: a 0 in copy mode keeps copying
    p_zero_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_out == bit_in && !bit_in && !last_in) |=> (bit_out == bit_in));

    // R5: inversion persists until the word ends
    p_flip_sticks_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_out != bit_in && !last_in) |=> (bit_out != bit_in));

    // R6: the word-end strobe returns to copy mode
    p_end_word_pass_r6: assert property (@(posedge clk) disable iff (rst)
        last_in |=> (bit_out == bit_in));
endmodule

// File: tb/twos_serial_conv_tb.sv
module twos_serial_conv_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic last_in = 1'b0;
    logic bit_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
        bit    word_end;
        logic [63:0] exp_word;
        int    len;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    twos_serial_conv u_dut (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .last_in (last_in),
        .bit_out (bit_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: bit_out=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: pushes expected bits, drives one bit per cycle at the falling edge
    task automatic send_word(input logic [63:0] val, input int len, input bit after_word);
        logic [63:0] mask;
        logic [63:0] neg;
        bit seen_one;
        mask = (len >= 64) ? '1 : ((64'd1 << len) - 64'd1);
        neg = ((~val) + 64'd1) & mask;
        seen_one = 1'b0;
        for (int i = 0; i < len; i++) begin
            item_t it;
            @(negedge clk);
            bit_in = val[i];
            last_in = (i == len - 1);
            it.exp = neg[i];
            if (i == 0) it.tag = after_word ? "R6" : "R1";
            else if (!seen_one) it.tag = "R4";
            else it.tag = "R5";
            if (i > 0 && seen_one && val[i-1] && (val & ((64'd1 << (i-1)) - 64'd1)) == 0)
                it.tag = "R3";
            if (it.tag == "R5" && it.exp == val[i]) it.tag = "R2";
            it.word_end = (i == len - 1);
            it.exp_word = neg;
            it.len = len;
            q.push_back(it);
            if (val[i]) seen_one = 1'b1;
        end
    endtask

    // monitor: samples mid-cycle, compares bits and whole words
    logic [63:0] got_word = '0;
    int got_idx = 0;
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(bit_out, it.exp, it.tag);
                got_word[got_idx] = bit_out;
                got_idx++;
                if (it.word_end) begin
                    total++;
                    if (got_word != it.exp_word) begin
                        bad++;
                        $display("FAIL R8: word=%h expected=%h len=%0d", got_word, it.exp_word, it.len);
                    end
                    got_word = '0;
                    got_idx = 0;
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // reset state (R1)
        bit_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #3 check(bit_out, 1'b1, "R1");
        bit_in = 1'b0;
        #2 check(bit_out, 1'b0, "R1");
        rst = 1'b0;

        // stated examples (R8)
        send_word(64'b0011, 4, 1'b0);
        send_word(64'b000, 3, 1'b1);
        send_word(64'b10, 2, 1'b1);
        send_word(64'b10110100, 8, 1'b1);
        // word end meets a copied 1 (R6)
        send_word(64'd1, 1, 1'b1);
        send_word(64'd1, 1, 1'b1);
        send_word(64'b1000, 4, 1'b1);
        send_word(64'b1111, 4, 1'b1);
        send_word(64'd0, 1, 1'b1);
        wait (q.size() == 0);
        @(negedge clk);
        #6;

        // same-cycle response (R7)
        @(negedge clk);
        bit_in = 1'b1; last_in = 1'b0;
        @(negedge clk);
        bit_in = 1'b0;
        #3 check(bit_out, 1'b1, "R7");
        bit_in = 1'b1;
        #3 check(bit_out, 1'b0, "R7");
        bit_in = 1'b0; last_in = 1'b1;
        #3 check(bit_out, 1'b1, "R5");
        @(negedge clk);
        last_in = 1'b0; bit_in = 1'b1;
        #3 check(bit_out, 1'b1, "R6");
        bit_in = 1'b0; last_in = 1'b1;
        #3 check(bit_out, 1'b0, "R6");

        // random back-to-back words
        for (int w = 0; w < 60; w++) begin
            int len;
            logic [63:0] v;
            len = 1 + ($urandom % 20);
            v = {$urandom, $urandom};
            if (w % 7 == 0) v = '0;
            v = v & ((64'd1 << len) - 64'd1);
            send_word(v, len, 1'b1);
        end
        wait (q.size() == 0);
        @(negedge clk);
        last_in = 1'b0;
        #6;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule